// File: doc/BRIEF.md
# Round-Robin Threshold Trip Sequencer

This block scans a programmable list of channel configurations in round-robin order and checks each conversion result against a low and a high limit kept for that list position. For every step it raises a conversion request that carries a 4-bit channel select and a differential flag for an external analog multiplexer. It then accepts one 8-bit sample and compares it. A sample strictly under the low limit sets a sticky low-trip flag. A sample strictly over the high limit sets a sticky high-trip flag. Each flag has its own interrupt enable. The list position that caused the most recent trip of each kind is kept for software.

Software reaches all storage through a small synchronous register bus with four 16-bit registers. A control register holds the run enable, the scan window (start and end index) and an access pointer. The access pointer is an index plus a list-select bit and a low/high-select bit. It steers reads and writes of the shared data register to one list entry, one low limit or one high limit. Conversion traffic runs over two valid/ready channels. The request channel goes out of the block and the sample channel comes in. The block applies back-pressure on the sample channel: it takes a sample only while it waits for the result of its own request. A request, once raised, holds its payload until it is accepted.

Top module: `trip_sequencer`

Register map (bus_addr): 0 = control, 1 = data, 2 = status, 3 = trip index.
Control bits: 0 run enable, 1 list-select, 2 high-select, [7:4] access index, [11:8] start index, [15:12] end index.
Status bits: 0 low-trip flag, 1 high-trip flag (both write-1-to-clear), 4 low-trip interrupt enable, 5 high-trip interrupt enable (both read/write).
Trip index bits: [3:0] position of the latest low trip, [11:8] position of the latest high trip.
List entry format in the data register: bits [3:0] channel, bit 4 differential. Limits use bits [7:0].

## Requirements
- R1: After reset, control, status and trip index read 0, irq, req_valid and smp_ready are 0, every list entry and low limit reads 0, and every high limit reads 0xFF.
- R2: Data-register accesses go to list entry [access index] when list-select is 1. When list-select is 0 they go to the low limit (high-select 0) or the high limit (high-select 1). A list entry keeps only bits [4:0], and unused upper bits read as zero.
- R3: While enabled, the block raises req_valid with the current entry's channel and differential bit. The payload stays stable until req_ready. For a differential entry, req_chan has bit 0 forced to 0, so it names the pair.
- R4: Steps visit indices from start to end, then wrap to start. Above 15 the index wraps to 0, so a window with end below start runs through 15 and 0.
- R5: smp_ready is high only after a request has been accepted and before its sample arrives. It is never high together with req_valid. A smp_valid outside that window is ignored.
- R6: A sample strictly below the current entry's low limit sets the low-trip flag. A sample equal to the limit does not.
- R7: A sample strictly above the current entry's high limit sets the high-trip flag. A sample equal to the limit does not.
- R8: Flags are sticky until software writes 1 to them. If a trip and a clear land on the same edge, the trip wins.
- R9: irq equals (low flag AND low enable) OR (high flag AND high enable).
- R10: Each trip records the list position that caused it in the trip index register.
- R11: Clearing the run enable lets the step in progress finish. After that no further request is raised, and the next enable starts again at the start index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational from bus_addr) |
| req_valid | output | 1 | Conversion request valid |
| req_ready | input | 1 | Conversion request accepted |
| req_chan | output | 4 | Channel select for the request |
| req_diff | output | 1 | Differential mode for the request |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Block waiting for a sample |
| smp_data | input | 8 | Conversion result |
| irq | output | 1 | Trip interrupt |

## Verification
A hardware trip and a software write-1-to-clear can hit the same flag on the same clock edge. The bench provokes this by driving a tripping sample and a status write that clears both flags in one cycle. It judges the result by reading the flag back as still set, with the interrupt and the trip index matching that step. Separately, it drives a stray sample strobe while a request is still pending. It confirms that no flag moves and that the request stays raised.

// File: rtl/trip_pkg.sv
package trip_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_TIDX = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_REQ,
    ST_WAIT
  } scan_state_e;
endpackage

// File: rtl/trip_store.sv
module trip_store #(
  parameter int unsigned N  = 16,
  parameter int unsigned SW = 8,
  parameter int unsigned CW = 4,
  localparam int unsigned IW = $clog2(N),
  localparam int unsigned EW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] acc_idx,
  input  logic          acc_list,
  input  logic          acc_high,
  input  logic          acc_wr,
  input  logic [SW-1:0] acc_wdata,
  output logic [SW-1:0] acc_rdata,
  input  logic [IW-1:0] scan_idx,
  output logic [CW-1:0] scan_chan,
  output logic          scan_diff,
  output logic [SW-1:0] scan_lo,
  output logic [SW-1:0] scan_hi
);
  logic [EW-1:0] list_q [N];
  logic [SW-1:0] lo_q   [N];
  logic [SW-1:0] hi_q   [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        list_q[i] <= '0;
        lo_q[i]   <= '0;
        hi_q[i]   <= '1;
      end
    end else if (acc_wr) begin
      if (acc_list)      list_q[acc_idx] <= acc_wdata[EW-1:0];
      else if (acc_high) hi_q[acc_idx]   <= acc_wdata;
      else               lo_q[acc_idx]   <= acc_wdata;
    end
  end

  always_comb begin
    if (acc_list)      acc_rdata = SW'(list_q[acc_idx]);
    else if (acc_high) acc_rdata = hi_q[acc_idx];
    else               acc_rdata = lo_q[acc_idx];
  end

  assign scan_chan = list_q[scan_idx][CW-1:0];
  assign scan_diff = list_q[scan_idx][CW];
  assign scan_lo   = lo_q[scan_idx];
  assign scan_hi   = hi_q[scan_idx];
endmodule

// File: rtl/trip_scan.sv
module trip_scan #(
  parameter int unsigned N  = 16,
  parameter int unsigned CW = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [IW-1:0] start_idx,
  input  logic [IW-1:0] end_idx,
  output logic [IW-1:0] cur_idx,
  input  logic [CW-1:0] ent_chan,
  input  logic          ent_diff,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [CW-1:0] req_chan,
  output logic          req_diff,
  input  logic          smp_valid,
  output logic          smp_ready,
  output logic          fire
);
  import trip_pkg::*;

  scan_state_e   state_q;
  logic [IW-1:0] cur_q, nxt_idx;
  logic [CW-1:0] chan_q;
  logic          diff_q;

  always_comb begin
    if (cur_q == end_idx)              nxt_idx = start_idx;
    else if (cur_q == IW'(N - 1))      nxt_idx = '0;
    else                               nxt_idx = cur_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      chan_q  <= '0;
      diff_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cur_q <= start_idx;
          if (en) state_q <= ST_LOAD;
        end
        ST_LOAD: begin
          if (!en) begin
            state_q <= ST_IDLE;
            cur_q   <= start_idx;
          end else begin
            chan_q  <= ent_diff ? (ent_chan & ~CW'(1)) : ent_chan;
            diff_q  <= ent_diff;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: if (req_ready) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (smp_valid) begin
            if (en) begin
              cur_q   <= nxt_idx;
              state_q <= ST_LOAD;
            end else begin
              cur_q   <= start_idx;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid = (state_q == ST_REQ);
  assign smp_ready = (state_q == ST_WAIT);
  assign req_chan  = chan_q;
  assign req_diff  = diff_q;
  assign fire      = smp_valid && smp_ready;
  assign cur_idx   = cur_q;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_chan) && $stable(req_diff));
  // R5
  chan_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && smp_ready));
  // R4
  window_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && en && cur_q == end_idx |=> cur_idx == $past(start_idx));
  // R11
  stop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !en |=> !req_valid && !smp_ready);
endmodule

// File: rtl/trip_flags.sv
module trip_flags #(
  parameter int unsigned SW = 8,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [SW-1:0] sample,
  input  logic [SW-1:0] lo_thr,
  input  logic [SW-1:0] hi_thr,
  input  logic [IW-1:0] idx,
  input  logic          stat_wr,
  input  logic          clr_lo,
  input  logic          clr_hi,
  input  logic          ie_lo_d,
  input  logic          ie_hi_d,
  output logic          lo_flag,
  output logic          hi_flag,
  output logic          lo_ie,
  output logic          hi_ie,
  output logic [IW-1:0] lo_at,
  output logic [IW-1:0] hi_at,
  output logic          irq
);
  logic lo_set, hi_set;

  assign lo_set = fire && (sample < lo_thr);
  assign hi_set = fire && (sample > hi_thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_flag <= 1'b0;
      hi_flag <= 1'b0;
      lo_ie   <= 1'b0;
      hi_ie   <= 1'b0;
      lo_at   <= '0;
      hi_at   <= '0;
    end else begin
      lo_flag <= lo_set | (lo_flag & ~(stat_wr & clr_lo));
      hi_flag <= hi_set | (hi_flag & ~(stat_wr & clr_hi));
      if (stat_wr) begin
        lo_ie <= ie_lo_d;
        hi_ie <= ie_hi_d;
      end
      if (lo_set) lo_at <= idx;
      if (hi_set) hi_at <= idx;
    end
  end

  assign irq = (lo_flag & lo_ie) | (hi_flag & hi_ie);

  // R6
  low_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (sample < lo_thr) |=> lo_flag);
  // R7
  high_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (sample > hi_thr) |=> hi_flag);
  // R8
  low_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr && clr_lo && !(fire && (sample < lo_thr)) |=> !lo_flag);
  // R8
  high_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_flag && !(stat_wr && clr_hi) |=> hi_flag);
  // R10
  high_at_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (sample > hi_thr) |=> hi_at == $past(idx));
endmodule

// File: rtl/trip_sequencer.sv
module trip_sequencer #(
  parameter int unsigned N  = 16,
  parameter int unsigned SW = 8,
  parameter int unsigned CW = 4,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [CW-1:0] req_chan,
  output logic          req_diff,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [SW-1:0] smp_data,
  output logic          irq
);
  import trip_pkg::*;
  localparam int unsigned IW = $clog2(N);

  logic [DW-1:0] ctrl_q;
  logic          run_en, sel_list, sel_high;
  logic [IW-1:0] acc_idx, win_start, win_end, cur_idx;
  logic [SW-1:0] acc_rdata, thr_lo, thr_hi;
  logic [CW-1:0] ent_chan;
  logic          ent_diff, fire;
  logic          lo_flag, hi_flag, lo_ie, hi_ie;
  logic [IW-1:0] lo_at, hi_at;
  logic          ctrl_wr, data_wr, stat_wr;

  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign data_wr = bus_wr && (bus_addr == A_DATA);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= bus_wdata;
  end

  assign run_en    = ctrl_q[0];
  assign sel_list  = ctrl_q[1];
  assign sel_high  = ctrl_q[2];
  assign acc_idx   = ctrl_q[4 +: IW];
  assign win_start = ctrl_q[8 +: IW];
  assign win_end   = ctrl_q[12 +: IW];

  trip_store #(.N(N), .SW(SW), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .acc_idx(acc_idx), .acc_list(sel_list), .acc_high(sel_high),
    .acc_wr(data_wr), .acc_wdata(bus_wdata[SW-1:0]), .acc_rdata(acc_rdata),
    .scan_idx(cur_idx), .scan_chan(ent_chan), .scan_diff(ent_diff),
    .scan_lo(thr_lo), .scan_hi(thr_hi)
  );

  trip_scan #(.N(N), .CW(CW)) u_scan (
    .clk(clk), .rst_n(rst_n), .en(run_en),
    .start_idx(win_start), .end_idx(win_end), .cur_idx(cur_idx),
    .ent_chan(ent_chan), .ent_diff(ent_diff),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_diff(req_diff),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .fire(fire)
  );

  trip_flags #(.SW(SW), .IW(IW)) u_flags (
    .clk(clk), .rst_n(rst_n), .fire(fire), .sample(smp_data),
    .lo_thr(thr_lo), .hi_thr(thr_hi), .idx(cur_idx),
    .stat_wr(stat_wr), .clr_lo(bus_wdata[0]), .clr_hi(bus_wdata[1]),
    .ie_lo_d(bus_wdata[4]), .ie_hi_d(bus_wdata[5]),
    .lo_flag(lo_flag), .hi_flag(hi_flag), .lo_ie(lo_ie), .hi_ie(hi_ie),
    .lo_at(lo_at), .hi_at(hi_at), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL: bus_rdata = ctrl_q;
      A_DATA: bus_rdata = DW'(acc_rdata);
      A_STAT: begin
        bus_rdata[0] = lo_flag;
        bus_rdata[1] = hi_flag;
        bus_rdata[4] = lo_ie;
        bus_rdata[5] = hi_ie;
      end
      default: begin
        bus_rdata[0 +: IW] = lo_at;
        bus_rdata[8 +: IW] = hi_at;
      end
    endcase
  end

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_flag && !hi_flag |-> !irq);
endmodule

// File: tb/tb_trip_sequencer.sv
module tb_trip_sequencer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        req_valid, req_ready = 1'b0;
  logic [3:0]  req_chan;
  logic        req_diff;
  logic        smp_valid = 1'b0, smp_ready;
  logic [7:0]  smp_data = '0;
  logic        irq;

  int vec = 0, bad = 0, ie_sh = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trip_sequencer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .req_diff(req_diff), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .irq(irq)
  );

  function automatic int e_chan(int i); return (i * 7 + 3) % 16; endfunction
  function automatic int e_diff(int i); return (i % 3 == 0) ? 1 : 0; endfunction
  function automatic int e_lo(int i); return 8 + i * 12; endfunction
  function automatic int e_hi(int i); return e_lo(i) + 40; endfunction
  function automatic int e_req(int i); return e_diff(i) ? (e_chan(i) & 14) : e_chan(i); endfunction
  function automatic int nxt(int c, int s, int e);
    return (c == e) ? s : (c + 1) % 16;
  endfunction
  function automatic int mk_ctrl(int en, int sl, int sh, int ix, int st, int nd);
    return en | (sl << 1) | (sh << 2) | (ix << 4) | (st << 8) | (nd << 12);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input int d);
    @(negedge clk);
    bus_addr = 2'(a); bus_wdata = 16'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output int d);
    @(negedge clk);
    bus_addr = 2'(a);
    #1 d = int'(bus_rdata);
  endtask

  task automatic set_ie(input int v);
    ie_sh = v;
    bus_write(2, v << 4);
  endtask

  task automatic do_step(input int idx, input int sample, input bit clash);
    int s, t, lo_e, hi_e;
    for (int w = 0; w < 40 && !req_valid; w++) @(negedge clk);
    chk("R3 request raised", req_valid, 1);
    chk("R3 request channel", req_chan, e_req(idx));
    chk("R3 request differential", req_diff, e_diff(idx));
    chk("R5 no sample ready during request", smp_ready, 0);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    chk("R5 sample ready after accept", smp_ready, 1);
    smp_valid = 1'b1; smp_data = 8'(sample);
    if (clash) begin
      bus_addr = 2'd2; bus_wdata = 16'(3 | (ie_sh << 4)); bus_wr = 1'b1;
    end
    @(negedge clk);
    smp_valid = 1'b0; bus_wr = 1'b0;
    lo_e = (sample < e_lo(idx)) ? 1 : 0;
    hi_e = (sample > e_hi(idx)) ? 1 : 0;
    bus_read(2, s);
    chk("R6 low flag", s & 1, lo_e);
    chk("R7 high flag", (s >> 1) & 1, hi_e);
    if (clash) chk("R8 trip wins over clear", s & 3, lo_e | (hi_e << 1));
    chk("R9 irq", irq, (lo_e & ie_sh) | (hi_e & (ie_sh >> 1)));
    if (lo_e || hi_e) begin
      bus_read(3, t);
      if (lo_e) chk("R10 low trip index", t & 15, idx);
      if (hi_e) chk("R10 high trip index", (t >> 8) & 15, idx);
      bus_read(2, s);
      chk("R8 flag sticky", s & 3, lo_e | (hi_e << 1));
      bus_write(2, 3 | (ie_sh << 4));
      bus_read(2, s);
      chk("R8 write-1 clears", s & 3, 0);
    end
  endtask

  task automatic stop_scan(input int ctrl_off, input int idx);
    bus_write(0, ctrl_off);
    do_step(idx, e_lo(idx) + 1, 1'b0);
    repeat (6) @(negedge clk);
    chk("R11 no request after stop", req_valid, 0);
    chk("R11 no sample ready after stop", smp_ready, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vec++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    int d, cur, smp;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 smp_ready", smp_ready, 0);
    bus_read(0, d); chk("R1 control", d, 0);
    bus_read(2, d); chk("R1 status", d, 0);
    bus_read(3, d); chk("R1 trip index", d, 0);
    for (int i = 0; i < 16; i++) begin
      bus_write(0, mk_ctrl(0, 1, 0, i, 0, 0)); bus_read(1, d); chk("R1 list entry", d, 0);
      bus_write(0, mk_ctrl(0, 0, 0, i, 0, 0)); bus_read(1, d); chk("R1 low limit", d, 0);
      bus_write(0, mk_ctrl(0, 0, 1, i, 0, 0)); bus_read(1, d); chk("R1 high limit", d, 255);
    end

    // R2 indirect load with junk upper bits, then read back everything
    for (int i = 0; i < 16; i++) begin
      bus_write(0, mk_ctrl(0, 1, 0, i, 0, 0));
      bus_write(1, 16'hFFE0 | (e_diff(i) << 4) | e_chan(i));
      bus_write(0, mk_ctrl(0, 0, 0, i, 0, 0));
      bus_write(1, 16'hAB00 | e_lo(i));
      bus_write(0, mk_ctrl(0, 0, 1, i, 0, 0));
      bus_write(1, 16'hCD00 | e_hi(i));
    end
    for (int i = 0; i < 16; i++) begin
      bus_write(0, mk_ctrl(0, 1, 0, i, 0, 0)); bus_read(1, d);
      chk("R2 list entry", d, (e_diff(i) << 4) | e_chan(i));
      bus_write(0, mk_ctrl(0, 0, 0, i, 0, 0)); bus_read(1, d);
      chk("R2 low limit", d, e_lo(i));
      bus_write(0, mk_ctrl(0, 0, 1, i, 0, 0)); bus_read(1, d);
      chk("R2 high limit", d, e_hi(i));
    end

    // R4 window 2..6, three rounds, sample sweep around both limits
    bus_write(0, mk_ctrl(1, 0, 0, 0, 2, 6));
    cur = 2;
    for (int k = 0; k < 15; k++) begin
      set_ie(k % 4);
      case (k % 6)
        0: smp = e_lo(cur) - 1;
        1: smp = e_lo(cur);
        2: smp = e_hi(cur);
        3: smp = e_hi(cur) + 1;
        4: smp = 0;
        default: smp = 255;
      endcase
      do_step(cur, smp, 1'b0);
      cur = nxt(cur, 2, 6);
    end
    stop_scan(mk_ctrl(0, 0, 0, 0, 2, 6), cur);

    // R4 window that wraps through 15 and 0; R11 restart at start
    bus_write(0, mk_ctrl(1, 0, 0, 0, 14, 1));
    cur = 14;
    set_ie(3);
    for (int k = 0; k < 8; k++) begin
      do_step(cur, (k % 2 == 0) ? e_lo(cur) - 1 : e_hi(cur) + 1, 1'b0);
      cur = nxt(cur, 14, 1);
    end
    stop_scan(mk_ctrl(0, 0, 0, 0, 14, 1), cur);

    // R8 clear and trip on the same edge, single-entry window
    bus_write(0, mk_ctrl(1, 0, 0, 0, 7, 7));
    do_step(7, e_lo(7) - 1, 1'b1);
    do_step(7, e_hi(7) + 1, 1'b1);

    // R5 stray sample while a request is pending
    for (int w = 0; w < 40 && !req_valid; w++) @(negedge clk);
    smp_valid = 1'b1; smp_data = 8'd0;
    repeat (2) @(negedge clk);
    smp_valid = 1'b0;
    bus_read(2, d);
    chk("R5 stray sample ignored", d & 3, 0);
    chk("R5 request still pending", req_valid, 1);
    do_step(7, e_hi(7) + 1, 1'b0);
    stop_scan(mk_ctrl(0, 0, 0, 0, 7, 7), 7);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule